// File: doc/BRIEF.md
# TFT Panel Line and Frame Timing Generator

This block produces the raster timing for an active-matrix colour TFT panel from a pixel clock that runs without pause. Each line is built from four programmable stretches counted in pixel clocks: a sync pulse, a back porch, the visible pixels and a front porch. Each frame uses the same four stretches, counted in whole lines. From this timing the block drives a horizontal sync, a vertical sync, an active-high data-enable strobe and a 24-bit pixel bus.

The block asks an upstream pixel source for every visible pixel one clock ahead of time through a request strobe. It samples the supplied pixel on the following edge and places it on the panel bus together with data enable. Software selects the polarity of each sync line on its own and can invert the clock sent to the panel. Timing values it writes are taken up only at a frame boundary, so a frame never mixes two sets of timing. While the enable input is low, the outputs are held idle.

Top module: `tft_timing_gen`

## Requirements
- R1: While `rst_n` is low, `hsync`, `vsync`, `de` and `pix_req` are 0 and `pix_out` is zero.
- R2: A line lasts sync + back + active + front pixel clocks. `hsync` is active for the first (sync) clocks of each line, and that count uses the value after the clamp of R3.
- R3: A programmed horizontal sync length of 0 acts as 1, so every line carries a one-clock sync pulse.
- R4: A frame lasts sync + back + active + front lines. `vsync` is active for the first (sync) lines and changes level only at the clock where `hsync` turns active.
- R5: A programmed vertical sync length of 0 acts as 1 line.
- R6: `de` is 1, active-high whatever the sync polarity, exactly for pixels that lie inside both the visible part of the line and the visible lines of the frame. A visible length of 0 on either axis keeps `de` low.
- R7: `pix_req` is 1 exactly one clock before each `de` clock. The `pix_in` value present at the rising edge that ends a request clock appears on `pix_out` during the following `de` clock.
- R8: `pix_out` is zero whenever `de` is 0.
- R9: `hsync_low` = 1 makes `hsync` active-low, and `vsync_low` = 1 does the same for `vsync`. The two bits act independently. With a bit at 0, its sync is active-high, which is the level right after reset.
- R10: `pan_clk` follows `clk` when `clk_invert` is 0 and is the inverse of `clk` when it is 1.
- R11: Timing inputs changed during a frame have no effect until the clock after the last pixel of the last line. While disabled, the block picks up the live values every clock.
- R12: From the first rising edge that sees `enable` low, `de`, `pix_req` and `pix_out` are 0 and each sync sits at its inactive level. The first rising edge that sees `enable` high starts pixel 0 of line 0, and that pixel's sync, `de` and `pix_req` levels appear on the outputs two edges later (`pix_req` one edge later).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Run the timing; low holds the outputs idle |
| h_sync_len | input | H_W | Horizontal sync length in clocks (0 acts as 1) |
| h_back_len | input | H_W | Horizontal back porch in clocks |
| h_active_len | input | H_W | Visible pixels per line |
| h_front_len | input | H_W | Horizontal front porch in clocks |
| v_sync_len | input | V_W | Vertical sync length in lines (0 acts as 1) |
| v_back_len | input | V_W | Vertical back porch in lines |
| v_active_len | input | V_W | Visible lines per frame |
| v_front_len | input | V_W | Vertical front porch in lines |
| hsync_low | input | 1 | 1: hsync active-low |
| vsync_low | input | 1 | 1: vsync active-low |
| clk_invert | input | 1 | 1: panel clock is the inverted pixel clock |
| pix_in | input | PIX_W | Pixel from the upstream source |
| pix_req | output | 1 | Pixel request, one clock ahead of data enable |
| pix_out | output | PIX_W | Pixel bus to the panel |
| de | output | 1 | Data enable, active-high |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| pan_clk | output | 1 | Clock to the panel |

## Verification
The bench aims at zero sync lengths and at zero visible lengths on each axis. A design without the clamp would produce lines with no sync pulse and frames with no vertical pulse. A design that ignored a zero visible length would leave `de` asserted, or let it wrap across the porches. It also rewrites timing in the middle of a frame and toggles `enable` at arbitrary points. A design that loaded the new values at once would tear the current frame. A design that kept its counters through a disable would restart off line 0. Polarity changes and clock inversion are also exercised, where swapped or shared polarity bits would invert the wrong sync. A request strobe offset by even one clock would show up as shifted or stale pixels on the bus.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;

   // Region of one axis (line or frame) the counter currently sits in
   typedef enum logic [1:0] {
      PH_SYNC   = 2'd0,
      PH_BACK   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_FRONT  = 2'd3
   } tft_phase_e;

   localparam int unsigned DEFAULT_PIX_W = 24;

endpackage

// File: rtl/tft_axis_ctr.sv
module tft_axis_ctr
   import tft_timing_pkg::*;
#(
   parameter int W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic          load,
   input  logic [W-1:0]  cfg_sync,
   input  logic [W-1:0]  cfg_back,
   input  logic [W-1:0]  cfg_act,
   input  logic [W-1:0]  cfg_front,
   output logic [W+1:0]  pos,
   output tft_phase_e    phase,
   output logic          last
);

   localparam int CW = W + 2;

   generate
      if (W < 2) begin : g_bad_width
         $error("tft_axis_ctr: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  s_sync, s_back, s_act, s_front;
   logic [CW-1:0] sync_end, back_end, act_end, total;

   // Shadow copy of the timing, refreshed only when load is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sync  <= '0;
         s_back  <= '0;
         s_act   <= '0;
         s_front <= '0;
      end else if (load) begin
         s_sync  <= cfg_sync;
         s_back  <= cfg_back;
         s_act   <= cfg_act;
         s_front <= cfg_front;
      end
   end

   always_comb begin
      sync_end = (s_sync == '0) ? CW'(1) : CW'(s_sync);
      back_end = sync_end + CW'(s_back);
      act_end  = back_end + CW'(s_act);
      total    = act_end + CW'(s_front);
   end

   assign last = (pos == total - CW'(1));

   always_comb begin
      if (pos < sync_end)      phase = PH_SYNC;
      else if (pos < back_end) phase = PH_BACK;
      else if (pos < act_end)  phase = PH_ACTIVE;
      else                     phase = PH_FRONT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (!run) begin
         pos <= '0;
      end else if (step) begin
         pos <= last ? '0 : pos + CW'(1);
      end
   end

   // R2 / R4: the position never leaves the programmed period
   p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pos < total);

   // R3 / R5: position zero always opens with a sync interval
   p_opens_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && pos == '0) |-> phase == PH_SYNC);

endmodule

// File: rtl/tft_out_stage.sv
module tft_out_stage
   import tft_timing_pkg::*;
#(
   parameter int PIX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  tft_phase_e       h_phase,
   input  tft_phase_e       v_phase,
   input  logic             hs_low,
   input  logic             vs_low,
   input  logic [PIX_W-1:0] pix_in,
   output logic             pix_req,
   output logic [PIX_W-1:0] pix_out,
   output logic             de,
   output logic             hsync,
   output logic             vsync
);

   generate
      if (PIX_W < 1) begin : g_bad_pix
         $error("tft_out_stage: PIX_W must be positive");
      end
   endgenerate

   logic a_hs, a_vs, a_de;

   // First stage: decode the counter position; its DE doubles as request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_hs <= 1'b0;
         a_vs <= 1'b0;
         a_de <= 1'b0;
      end else if (!enable) begin
         a_hs <= 1'b0;
         a_vs <= 1'b0;
         a_de <= 1'b0;
      end else begin
         a_hs <= (h_phase == PH_SYNC);
         a_vs <= (v_phase == PH_SYNC);
         a_de <= (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
      end
   end

   assign pix_req = a_de;

   // Second stage: panel-facing registers, polarity applied here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync   <= 1'b0;
         vsync   <= 1'b0;
         de      <= 1'b0;
         pix_out <= '0;
      end else if (!enable) begin
         hsync   <= hs_low;
         vsync   <= vs_low;
         de      <= 1'b0;
         pix_out <= '0;
      end else begin
         hsync   <= a_hs ^ hs_low;
         vsync   <= a_vs ^ vs_low;
         de      <= a_de;
         pix_out <= a_de ? pix_in : '0;
      end
   end

   // R7: a request is always followed by a data-enable clock
   p_req_then_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && pix_req) |=> de);

   // R7: the pixel on the bus is the one sampled at the end of the request
   p_pix_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && pix_req) |=> pix_out == $past(pix_in));

   // R8: a blank bus outside data enable
   p_dark_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !de |-> pix_out == '0);

   // R12: idle outputs one edge after enable is seen low
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!de && !pix_req && hsync == $past(hs_low) && vsync == $past(vs_low)));

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
   import tft_timing_pkg::*;
#(
   parameter int H_W        = 12,
   parameter int V_W        = 11,
   parameter int PIX_W      = DEFAULT_PIX_W,
   parameter bit CLK_INV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [H_W-1:0]   h_sync_len,
   input  logic [H_W-1:0]   h_back_len,
   input  logic [H_W-1:0]   h_active_len,
   input  logic [H_W-1:0]   h_front_len,
   input  logic [V_W-1:0]   v_sync_len,
   input  logic [V_W-1:0]   v_back_len,
   input  logic [V_W-1:0]   v_active_len,
   input  logic [V_W-1:0]   v_front_len,
   input  logic             hsync_low,
   input  logic             vsync_low,
   input  logic             clk_invert,
   input  logic [PIX_W-1:0] pix_in,
   output logic             pix_req,
   output logic [PIX_W-1:0] pix_out,
   output logic             de,
   output logic             hsync,
   output logic             vsync,
   output logic             pan_clk
);

   generate
      if (H_W < 2 || V_W < 2) begin : g_bad_axis
         $error("tft_timing_gen: counter widths must be at least 2");
      end
   endgenerate

   logic [H_W+1:0] h_pos;
   logic [V_W+1:0] v_pos;
   tft_phase_e     h_phase, v_phase;
   logic           h_last, v_last;
   logic           frame_end, take_cfg;

   assign frame_end = h_last && v_last;
   // Capture new timing only between frames, or continuously while idle
   assign take_cfg  = !enable || frame_end;

   tft_axis_ctr #(.W(H_W)) i_h_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable),
      .step      (1'b1),
      .load      (take_cfg),
      .cfg_sync  (h_sync_len),
      .cfg_back  (h_back_len),
      .cfg_act   (h_active_len),
      .cfg_front (h_front_len),
      .pos       (h_pos),
      .phase     (h_phase),
      .last      (h_last)
   );

   tft_axis_ctr #(.W(V_W)) i_v_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (enable),
      .step      (h_last),
      .load      (take_cfg),
      .cfg_sync  (v_sync_len),
      .cfg_back  (v_back_len),
      .cfg_act   (v_active_len),
      .cfg_front (v_front_len),
      .pos       (v_pos),
      .phase     (v_phase),
      .last      (v_last)
   );

   tft_out_stage #(.PIX_W(PIX_W)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .h_phase (h_phase),
      .v_phase (v_phase),
      .hs_low  (hsync_low),
      .vs_low  (vsync_low),
      .pix_in  (pix_in),
      .pix_req (pix_req),
      .pix_out (pix_out),
      .de      (de),
      .hsync   (hsync),
      .vsync   (vsync)
   );

   generate
      if (CLK_INV_EN) begin : g_clk_inv
         assign pan_clk = clk_invert ? ~clk : clk;
      end else begin : g_clk_direct
         assign pan_clk = clk;
      end
   endgenerate

   // R4: the line count only moves at the end of a line
   p_vline_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !h_last) |=> $stable(v_pos));

   // R11: line wrap and frame wrap agree on where a frame ends
   p_frame_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && frame_end) |=> (h_pos == '0 && v_pos == '0));

endmodule

// File: tb/test_tft_timing_gen.sv
`timescale 1ns/1ps
module test_tft_timing_gen;

   localparam int HW = 12;
   localparam int VW = 11;
   localparam int PW = 24;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, enable, hsync_low, vsync_low, clk_invert;
   logic [HW-1:0] h_sync_len, h_back_len, h_active_len, h_front_len;
   logic [VW-1:0] v_sync_len, v_back_len, v_active_len, v_front_len;
   logic [PW-1:0] pix_in;
   wire           pix_req, de, hsync, vsync, pan_clk;
   wire  [PW-1:0] pix_out;

   tft_timing_gen i_tft_timing_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .h_sync_len(h_sync_len), .h_back_len(h_back_len),
      .h_active_len(h_active_len), .h_front_len(h_front_len),
      .v_sync_len(v_sync_len), .v_back_len(v_back_len),
      .v_active_len(v_active_len), .v_front_len(v_front_len),
      .hsync_low(hsync_low), .vsync_low(vsync_low), .clk_invert(clk_invert),
      .pix_in(pix_in), .pix_req(pix_req), .pix_out(pix_out), .de(de),
      .hsync(hsync), .vsync(vsync), .pan_clk(pan_clk)
   );

   int    checks = 0;
   int    errors = 0;
   int    cyc = 0;
   bit    done = 0;
   string tag = "R1";

   // Reference model state
   int mh, mv;
   int sh_s, sh_b, sh_a, sh_f, sv_s, sv_b, sv_a, sv_f;
   bit ma_hs, ma_vs, ma_de;
   bit e_hs, e_vs, e_de;
   logic [PW-1:0] e_pix;

   function automatic int clamp1(int x);
      return (x == 0) ? 1 : x;
   endfunction

   function automatic bit in_win(int p, int lo, int len);
      return (p >= lo) && (p < lo + len);
   endfunction

   task automatic load_shadow();
      sh_s = int'(h_sync_len); sh_b = int'(h_back_len);
      sh_a = int'(h_active_len); sh_f = int'(h_front_len);
      sv_s = int'(v_sync_len); sv_b = int'(v_back_len);
      sv_a = int'(v_active_len); sv_f = int'(v_front_len);
   endtask

   always @(posedge clk) begin
      int hs, vs, htot, vtot;
      if (!rst_n) begin
         mh = 0; mv = 0;
         sh_s = 0; sh_b = 0; sh_a = 0; sh_f = 0;
         sv_s = 0; sv_b = 0; sv_a = 0; sv_f = 0;
         ma_hs = 0; ma_vs = 0; ma_de = 0;
         e_hs = 0; e_vs = 0; e_de = 0; e_pix = '0;
      end else begin
         if (enable) begin
            e_hs = ma_hs ^ hsync_low;
            e_vs = ma_vs ^ vsync_low;
            e_de = ma_de;
            e_pix = ma_de ? pix_in : '0;
            hs = clamp1(sh_s);
            vs = clamp1(sv_s);
            htot = hs + sh_b + sh_a + sh_f;
            vtot = vs + sv_b + sv_a + sv_f;
            ma_hs = (mh < hs);
            ma_vs = (mv < vs);
            ma_de = in_win(mh, hs + sh_b, sh_a) && in_win(mv, vs + sv_b, sv_a);
            if (mh == htot - 1) begin
               mh = 0;
               if (mv == vtot - 1) begin
                  mv = 0;
                  load_shadow();
               end else begin
                  mv = mv + 1;
               end
            end else begin
               mh = mh + 1;
            end
         end else begin
            e_hs = hsync_low; e_vs = vsync_low; e_de = 0; e_pix = '0;
            ma_hs = 0; ma_vs = 0; ma_de = 0;
            mh = 0; mv = 0;
            load_shadow();
         end
      end
   end

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s [%s] %s: actual %h expected %h", req, tag, what, act, expv);
      end
   endtask

   task automatic step_cycle();
      @(posedge clk);
      #1;
      chk(pan_clk == !clk_invert, "R10", "pan_clk high phase",
          32'(pan_clk), 32'(!clk_invert));
      @(negedge clk);
      #1;
      chk(pan_clk == clk_invert, "R10", "pan_clk low phase",
          32'(pan_clk), 32'(clk_invert));
      chk(hsync == e_hs, "R2", "hsync", 32'(hsync), 32'(e_hs));
      chk(vsync == e_vs, "R4", "vsync", 32'(vsync), 32'(e_vs));
      chk(de == e_de, "R6", "de", 32'(de), 32'(e_de));
      chk(pix_req == ma_de, "R7", "pix_req", 32'(pix_req), 32'(ma_de));
      chk(pix_out == e_pix, e_de ? "R7" : "R8", "pix_out", 32'(pix_out), 32'(e_pix));
      pix_in = PW'($urandom);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step_cycle();
   endtask

   task automatic set_cfg(int hs, int hb, int ha, int hf, int vs, int vb, int va, int vf);
      h_sync_len = HW'(hs); h_back_len = HW'(hb);
      h_active_len = HW'(ha); h_front_len = HW'(hf);
      v_sync_len = VW'(vs); v_back_len = VW'(vb);
      v_active_len = VW'(va); v_front_len = VW'(vf);
   endtask

   initial begin
      void'($urandom(32'h1F2E3D4C));
      rst_n = 0; enable = 0; hsync_low = 0; vsync_low = 0; clk_invert = 0;
      pix_in = '0;
      set_cfg(2, 3, 5, 2, 1, 1, 3, 1);

      // R1: reset state
      tag = "R1";
      run(3);
      chk(hsync == 0 && vsync == 0, "R1", "syncs in reset", 32'({hsync, vsync}), 32'(0));
      chk(de == 0 && pix_req == 0, "R1", "de/req in reset", 32'({de, pix_req}), 32'(0));
      chk(pix_out == '0, "R1", "pix_out in reset", 32'(pix_out), 32'(0));
      rst_n = 1;
      run(2);

      tag = "R2";  enable = 1; run(170);
      tag = "R12"; enable = 0; run(3);
      chk(de == 0 && hsync == 0 && vsync == 0, "R12", "idle levels",
          32'({de, hsync, vsync}), 32'(0));
      enable = 1;
      run(2);
      chk(hsync == 1 && vsync == 1, "R12", "frame start after enable",
          32'({hsync, vsync}), 32'(3));
      run(100);

      tag = "R3";  set_cfg(0, 2, 4, 1, 1, 1, 3, 1); run(200);
      tag = "R5";  set_cfg(1, 1, 4, 1, 0, 1, 3, 2); run(250);
      tag = "R6";  set_cfg(1, 1, 0, 2, 1, 1, 3, 1); run(150);
      set_cfg(1, 1, 4, 2, 1, 1, 0, 1); run(150);
      tag = "R9";  set_cfg(2, 1, 3, 1, 2, 1, 2, 1);
      hsync_low = 1; run(150);
      hsync_low = 0; vsync_low = 1; run(150);
      vsync_low = 0;
      tag = "R10"; clk_invert = 1; run(30); clk_invert = 0;
      tag = "R11"; run(23); set_cfg(3, 2, 6, 3, 1, 2, 4, 1); run(40);
      set_cfg(1, 0, 2, 0, 1, 0, 2, 0); run(300);
      tag = "R12"; run(17); enable = 0; run(6); enable = 1; run(120);

      tag = "R7";
      for (int it = 0; it < 25; it++) begin
         set_cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 6),
                 $urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 2),
                 $urandom_range(0, 4), $urandom_range(0, 2));
         hsync_low = 1'($urandom_range(0, 1));
         vsync_low = 1'($urandom_range(0, 1));
         clk_invert = 1'($urandom_range(0, 1));
         run($urandom_range(100, 250));
         if ($urandom_range(0, 3) == 0) begin
            enable = 0; run($urandom_range(1, 5)); enable = 1;
         end
         set_cfg($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 6),
                 $urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 2),
                 $urandom_range(0, 4), $urandom_range(0, 2));
         run($urandom_range(100, 250));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog [%s]: actual %0d cycles expected completion", tag, cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule